// File: doc/BRIEF.md
# Configurable Two-Level Sum-of-Products Array

This block computes several Boolean outputs from a small input vector as sums of product terms. Its configuration lives in registers: for each product term, one literal code for each input selects the true input, its complement, or no dependence. A connection row then states which outputs the term drives. Evaluation from `in_vec` to `out_vec` is purely combinational. Only configuration changes pass through a clock edge.

Two OR-plane arrangements can be chosen with `fixed_mode`. In the shared arrangement, any term may drive any number of outputs. One term can therefore serve several functions while using only one slot. In the grouped arrangement, output k is the OR of its own run of `GROUP` consecutive terms starting at term k*GROUP, and the connection rows are not used. A group slot that is not needed is made inert by giving it a contradictory literal code.

The configuration is written one term at a time through a synchronous port addressed by term index.

Top module: `pla_array`

## Requirements
- R1: After reset, every literal code is 11 and every connection bit is 0, so `out_vec` is all zero for every input value in both arrangements.
- R2: Input i of a term is controlled by literal code bits [2i+1:2i] of that term. Bit 2i set requires `in_vec[i]`=1, bit 2i+1 set requires `in_vec[i]`=0, and code 00 leaves the term independent of input i. The term is true when all of its requirements hold.
- R3: A term with code 11 on any input is false for every input value.
- R4: A term whose codes are all 00 is true for every input value.
- R5: With `fixed_mode`=0, `out_vec[o]` is the OR of the true terms whose connection bit o (bit o of `cfg_conn` when the term was written) is 1. An output with no connected true term is 0.
- R6: With `fixed_mode`=0, a single term whose connection row has several bits set drives each of those outputs.
- R7: With `fixed_mode`=1, `out_vec[o]` is the OR of terms o*GROUP to o*GROUP+GROUP-1, and every connection bit has no effect.
- R8: When `cfg_we`=1 at a rising edge, term `cfg_term` takes `cfg_lits` and `cfg_conn`, and the outputs show the new term only after that edge. When `cfg_we`=0, the stored configuration is unchanged whatever the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| fixed_mode | input | 1 | 0: shared OR plane, 1: grouped OR plane |
| cfg_we | input | 1 | Write strobe for one term |
| cfg_term | input | TAW | Index of the term written |
| cfg_lits | input | 2*N_IN | Literal codes, two bits per input |
| cfg_conn | input | N_OUT | Connection row, one bit per output |
| in_vec | input | N_IN | Function inputs |
| out_vec | output | N_OUT | Function outputs |

## Verification
The hardest condition to reach from the ports is the grouped arrangement running while the connection rows contain data that would give different outputs in the shared arrangement. This shows that the rows are ignored, and not just empty. The bench therefore loads the code-converter personality with random connection rows and checks all sixteen input values against the converter equations. It then runs random personalities in randomly chosen arrangements. Those literal codes often contain 11 and 00 fields, which exercises the always-false and always-true terms.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;
    // literal code per input, two bits: bit 0 wants 1, bit 1 wants 0
    localparam logic [1:0] LIT_ANY   = 2'b00;
    localparam logic [1:0] LIT_HIGH  = 2'b01;
    localparam logic [1:0] LIT_LOW   = 2'b10;
    localparam logic [1:0] LIT_NEVER = 2'b11;

    typedef enum logic {
        PLANE_SHARED  = 1'b0,
        PLANE_GROUPED = 1'b1
    } plane_e;
endpackage

// File: rtl/pla_cfg_store.sv
`timescale 1ns/1ps
module pla_cfg_store #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 16,
    parameter int N_OUT  = 4,
    parameter int TAW    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [TAW-1:0]                term,
    input  logic [2*N_IN-1:0]             lits_in,
    input  logic [N_OUT-1:0]              conn_in,
    output logic [N_TERM-1:0][2*N_IN-1:0] lits_q,
    output logic [N_TERM-1:0][N_OUT-1:0]  conn_q
);
    import pla_pkg::*;

    localparam int LW = 2 * N_IN;

    typedef struct packed {
        logic [N_TERM-1:0][LW-1:0]    lits;
        logic [N_TERM-1:0][N_OUT-1:0] conn;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && (int'(term) < N_TERM)) begin
            cfg_d.lits[term] = lits_in;
            cfg_d.conn[term] = conn_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERM; t++) begin
                cfg_q.lits[t] <= {N_IN{LIT_NEVER}};
                cfg_q.conn[t] <= '0;
            end
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lits_q = cfg_q.lits;
    assign conn_q = cfg_q.conn;

    // R8: no strobe, no change
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
    // R8: a strobe lands in the addressed slot
    p_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(term) < N_TERM) |=>
            (lits_q[$past(term)] == $past(lits_in)) && (conn_q[$past(term)] == $past(conn_in)));
endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_IN-1:0]               x,
    input  logic [N_TERM-1:0][2*N_IN-1:0] lits,
    output logic [N_TERM-1:0]             hit
);
    import pla_pkg::*;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_IN-1:0] lit_ok;
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            logic [1:0] code;
            assign code      = lits[t][2*i +: 2];
            assign lit_ok[i] = (!code[0] || x[i]) && (!code[1] || !x[i]);
        end
        assign hit[t] = &lit_ok;

        logic contradictory;
        always_comb begin
            contradictory = 1'b0;
            for (int i = 0; i < N_IN; i++)
                if (lits[t][2*i +: 2] == LIT_NEVER) contradictory = 1'b1;
        end

        // R3: a contradictory literal forces the term false
        p_contra_r3: assert property (@(posedge clk) disable iff (!rst_n)
            contradictory |-> !hit[t]);
        // R4: an empty term is always true
        p_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (lits[t] == '0) |-> hit[t]);
    end
endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
    parameter int N_TERM = 16,
    parameter int N_OUT  = 4,
    parameter int GROUP  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         grouped,
    input  logic [N_TERM-1:0]            hit,
    input  logic [N_TERM-1:0][N_OUT-1:0] conn,
    output logic [N_OUT-1:0]             y
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int FIRST = o * GROUP;

        logic [N_TERM-1:0] col;
        logic [GROUP-1:0]  grp;
        logic              shared_or, group_or;

        for (genvar t = 0; t < N_TERM; t++) begin : g_col
            assign col[t] = conn[t][o];
        end

        for (genvar g = 0; g < GROUP; g++) begin : g_grp
            if (FIRST + g < N_TERM) begin : g_in
                assign grp[g] = hit[FIRST + g];
            end else begin : g_off
                assign grp[g] = 1'b0;
            end
        end

        assign shared_or = |(hit & col);
        assign group_or  = |grp;
        assign y[o]      = grouped ? group_or : shared_or;

        // R5: nothing connected and true means a low output
        p_shared_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!grouped && ((hit & col) == '0)) |-> !y[o]);
        // R7: a silent group means a low output whatever the rows hold
        p_group_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (grouped && grp == '0) |-> !y[o]);

        for (genvar t = 0; t < N_TERM; t++) begin : g_fan
            // R6: every connected true term reaches its output
            p_fanout_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!grouped && hit[t] && conn[t][o]) |-> y[o]);
        end
    end
endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array #(
    parameter int  N_IN   = 4,
    parameter int  N_TERM = 16,
    parameter int  N_OUT  = 4,
    parameter int  GROUP  = 4,
    localparam int TAW    = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fixed_mode,
    input  logic              cfg_we,
    input  logic [TAW-1:0]    cfg_term,
    input  logic [2*N_IN-1:0] cfg_lits,
    input  logic [N_OUT-1:0]  cfg_conn,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  out_vec
);
    import pla_pkg::*;

    logic [N_TERM-1:0][2*N_IN-1:0] lits;
    logic [N_TERM-1:0][N_OUT-1:0]  conn;
    logic [N_TERM-1:0]             hit;
    plane_e                        plane;

    assign plane = plane_e'(fixed_mode);

    pla_cfg_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .TAW(TAW)) i_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .term(cfg_term),
        .lits_in(cfg_lits), .conn_in(cfg_conn), .lits_q(lits), .conn_q(conn)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) i_and (
        .clk(clk), .rst_n(rst_n), .x(in_vec), .lits(lits), .hit(hit)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .GROUP(GROUP)) i_or (
        .clk(clk), .rst_n(rst_n), .grouped(plane == PLANE_GROUPED),
        .hit(hit), .conn(conn), .y(out_vec)
    );

    // R1: the first cycle after reset shows a dark array
    logic first_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= 1'b0;
    end
    p_reset_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> (out_vec == '0));
endmodule

// File: tb/test_pla_array.sv
`timescale 1ns/1ps
module test_pla_array;
    localparam int NI = 4, NT = 16, NO = 4, GR = 4;
    localparam logic [1:0] X = 2'b00, T = 2'b01, C = 2'b10, N = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fixed_mode = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_term = '0;
    logic [7:0]    cfg_lits = '0;
    logic [3:0]    cfg_conn = '0;
    logic [3:0]    in_vec = '0;
    logic [3:0]    out_vec;

    int checks = 0, errors = 0;
    logic [7:0] sh_lits [NT];
    logic [3:0] sh_conn [NT];

    always #4 clk = ~clk;

    pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO), .GROUP(GR)) i_pla_array (
        .clk(clk), .rst_n(rst_n), .fixed_mode(fixed_mode), .cfg_we(cfg_we),
        .cfg_term(cfg_term), .cfg_lits(cfg_lits), .cfg_conn(cfg_conn),
        .in_vec(in_vec), .out_vec(out_vec)
    );

    function automatic logic [7:0] mk(logic [1:0] c3, logic [1:0] c2, logic [1:0] c1, logic [1:0] c0);
        return {c3, c2, c1, c0};
    endfunction

    function automatic logic [3:0] model(logic [3:0] x, logic fx);
        logic [3:0] r = '0;
        for (int t = 0; t < NT; t++) begin
            logic h = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (sh_lits[t][2*i] && !x[i]) h = 1'b0;
                if (sh_lits[t][2*i+1] && x[i]) h = 1'b0;
            end
            for (int o = 0; o < NO; o++)
                if (h && (fx ? (t / GR == o) : sh_conn[t][o])) r[o] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(string req, logic [3:0] exp);
        checks++;
        if (out_vec !== exp) begin
            errors++;
            $display("FAIL %s in=%b mode=%b actual=%b expected=%b", req, in_vec, fixed_mode, out_vec, exp);
        end
    endtask

    task automatic wr(int t, logic [7:0] l, logic [3:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_term = 4'(t); cfg_lits = l; cfg_conn = c;
        @(negedge clk);
        cfg_we = 1'b0;
        sh_lits[t] = l; sh_conn[t] = c;
    endtask

    task automatic sweep_model(string req);
        for (int v = 0; v < 16; v++) begin
            in_vec = 4'(v); #1;
            check(req, model(4'(v), fixed_mode));
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int t = 0; t < NT; t++) begin sh_lits[t] = 8'hFF; sh_conn[t] = '0; end
        #20 rst_n = 1'b1;

        // R1: dark after reset, both arrangements
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            fixed_mode = 1'(m);
            for (int v = 0; v < 16; v++) begin in_vec = 4'(v); #1; check("R1", 4'b0000); end
        end

        // R8 + R4: write lands only after the edge; empty term is true
        fixed_mode = 1'b0; in_vec = 4'b1010;
        @(negedge clk);
        cfg_we = 1'b1; cfg_term = 4'd3; cfg_lits = 8'h00; cfg_conn = 4'b0100;
        #1 check("R8 before edge", 4'b0000);
        @(negedge clk); cfg_we = 1'b0;
        sh_lits[3] = 8'h00; sh_conn[3] = 4'b0100;
        #1 check("R8 after edge", 4'b0100);
        sweep_model("R4");

        // R8: strobe low leaves configuration alone
        @(negedge clk);
        cfg_term = 4'd3; cfg_lits = 8'hFF; cfg_conn = 4'b1111;
        @(negedge clk); @(negedge clk);
        sweep_model("R8 hold");

        // R2 R5 R6: shared personality, A=in[2] B=in[1] C=in[0]
        wr(0, mk(X, T, T, X), 4'b0110);   // AB   -> F1 F2
        wr(1, mk(X, X, C, T), 4'b1000);   // B'C  -> F3
        wr(2, mk(X, T, X, C), 4'b0010);   // AC'  -> F1
        wr(3, mk(X, X, C, C), 4'b0101);   // B'C' -> F0 F2
        wr(4, mk(X, T, X, X), 4'b1001);   // A    -> F0 F3
        for (int t = 5; t < NT; t++) wr(t, mk(N, X, X, X), 4'b1111);
        fixed_mode = 1'b0;
        for (int v = 0; v < 16; v++) begin
            logic a, b, c;
            logic [3:0] e;
            a = v[2]; b = v[1]; c = v[0];
            e[0] = a | (~b & ~c);
            e[1] = (a & ~c) | (a & b);
            e[2] = (~b & ~c) | (a & b);
            e[3] = (~b & c) | a;
            in_vec = 4'(v); #1;
            check("R2 R5 R6 shared personality", e);
        end

        // R3 R7: code converter in grouped arrangement, random rows ignored
        wr(0,  mk(T, X, X, X), 4'($urandom));
        wr(1,  mk(X, T, X, T), 4'($urandom));
        wr(2,  mk(X, T, T, X), 4'($urandom));
        wr(3,  mk(N, X, X, X), 4'($urandom));
        wr(4,  mk(X, T, C, X), 4'($urandom));
        wr(5,  mk(X, N, X, X), 4'($urandom));
        wr(6,  mk(X, X, N, X), 4'($urandom));
        wr(7,  mk(X, X, X, N), 4'($urandom));
        wr(8,  mk(X, T, X, X), 4'($urandom));
        wr(9,  mk(X, X, T, X), 4'($urandom));
        wr(10, mk(N, N, X, X), 4'($urandom));
        wr(11, mk(N, N, N, N), 4'($urandom));
        wr(12, mk(C, C, C, T), 4'($urandom));
        wr(13, mk(X, T, T, T), 4'($urandom));
        wr(14, mk(T, X, X, C), 4'($urandom));
        wr(15, mk(X, C, T, C), 4'($urandom));
        fixed_mode = 1'b1;
        for (int v = 0; v < 16; v++) begin
            logic a, b, c, d;
            logic [3:0] e;
            a = v[3]; b = v[2]; c = v[1]; d = v[0];
            e[0] = a | (b & d) | (b & c);
            e[1] = b & ~c;
            e[2] = b | c;
            e[3] = (~a & ~b & ~c & d) | (b & c & d) | (a & ~d) | (~b & c & ~d);
            in_vec = 4'(v); #1;
            check("R3 R7 grouped converter", e);
        end

        // R2 R3 R4 R5 R7: random personalities in both arrangements
        for (int r = 0; r < 24; r++) begin
            for (int t = 0; t < NT; t++) wr(t, 8'($urandom), 4'($urandom));
            fixed_mode = 1'($urandom);
            sweep_model("R2 R5 R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule